// File: doc/BRIEF.md
# SAR ADC Capture Controller

The controller runs an external successive-approximation converter and turns its serial results into 16-bit words for a parallel host bus. It starts each conversion with a rising edge on the convert strobe. It then waits until the converter has finished. The wait is either a programmed number of clocks or, in busy-indicator mode, a high-to-low edge on the serial data line. After the wait it clocks the result in MSB first on its own serial clock. The data input line of the converter is held at a fixed level.

Each finished result goes onto the host bus with a one-cycle ready pulse. The host uses this pulse as its data interrupt. A 14-bit result is right-justified on the bus. A 16-bit result fills the bus. An 18-bit result is split into two words with the upper part first, and each word gets its own pulse. A coding input selects whether the unused upper bits are sign-extended (two's complement) or zero-filled (straight binary).

Conversions either repeat at a fixed period for as long as a run input is high, or run for a requested count and then stop. A turbo input selects the shorter period and the shorter conversion wait.

Top module: `sar_capture_ctrl`

## Requirements
- R1: While rst_ni is low and right after it is released, cnv_o, sck_o and drdy_o are low and data_o is zero.
- R2: Each conversion begins with a low-to-high edge on cnv_o. cnv_o then stays high for CNV_W cycles. sck_o is low whenever cnv_o rises.
- R3: With busy_ind_i low, the first rising edge of sck_o comes exactly WAIT+SCK_HALF clock cycles after cnv_o falls. WAIT is WAIT_TURBO when turbo_i is high and WAIT_NORM when it is low.
- R4: With busy_ind_i high, no sck_o edge occurs until sdo_i has gone from high to low after the conversion started. Readout begins only after that fall.
- R5: Each conversion produces exactly N rising edges on sck_o, where N is 14, 16 or 18 according to res_sel_i (0, 1, 2; the code 3 acts as 1). sck_o is high for SCK_HALF cycles and low for SCK_HALF cycles. The bit shifted in on each edge is the sdo_i level at the end of the high phase, MSB first.
- R6: For a 14-bit result r, data_o = {2{twos_i & r[13]}, r[13:0]}.
- R7: For a 16-bit result r, data_o = r[15:0].
- R8: For an 18-bit result r, two words are sent: first {14{twos_i & r[17]}, r[17:16]}, then r[15:0]. Each word has its own drdy_o pulse.
- R9: drdy_o is high for a single cycle per word. data_o changes only in a cycle where drdy_o is high.
- R10: With burst_i low and run_i high, consecutive rising edges of cnv_o are exactly PERIOD_TURBO cycles apart (turbo_i high) or PERIOD_NORM cycles apart (turbo_i low). Once run_i drops, no further conversion starts.
- R11: With burst_i high, a start_i pulse while idle starts exactly burst_cnt_i conversions, spaced as in R10, and then cnv_o stays low. A count of zero starts none.
- R12: sdi_o always equals SDI_LEVEL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_sel_i | input | 2 | Result width: 0 = 14, 1 = 16, 2 = 18 bits |
| twos_i | input | 1 | 1 = sign-extend, 0 = zero-fill upper bits |
| busy_ind_i | input | 1 | 1 = end of conversion taken from SDO falling edge |
| turbo_i | input | 1 | Selects turbo period and wait |
| run_i | input | 1 | Continuous conversion enable |
| burst_i | input | 1 | Selects counted (burst) scheduling |
| start_i | input | 1 | Starts a burst while idle |
| burst_cnt_i | input | CNT_W | Number of conversions per burst |
| sdo_i | input | 1 | Serial data from converter |
| cnv_o | output | 1 | Convert strobe |
| sck_o | output | 1 | Serial clock to converter |
| sdi_o | output | 1 | Static level on converter data input |
| data_o | output | 16 | Parallel result word |
| drdy_o | output | 1 | One-cycle word-ready interrupt |

## Verification
Several internal faults show up on the ports within one conversion. A wrong bit counter or phase counter changes the number of sck_o edges, or the word seen at the next drdy_o pulse. A wrong wait count moves the first sck_o edge relative to the fall of cnv_o. A lost busy-indicator edge lets sck_o run while the converter model is still busy. A scheduler fault shows up at the next cnv_o rise, as a wrong spacing, or after a few hundred cycles, as a missing or extra conversion. The packer's coding and split faults are exposed by directed samples: full scale, sign bit only, zero, and random codes.

// File: rtl/sar_cap_pkg.sv
package sar_cap_pkg;
  localparam int unsigned RAW_W = 18;
  localparam int unsigned OUT_W = 16;
  localparam int unsigned SHORT_W = 14;

  localparam logic [1:0] RES_14 = 2'd0;
  localparam logic [1:0] RES_16 = 2'd1;
  localparam logic [1:0] RES_18 = 2'd2;

  typedef enum logic [2:0] {ST_IDLE, ST_CNV, ST_WAIT, ST_SHIFT, ST_GAP} ctl_st_e;

  function automatic logic [4:0] res_bits(input logic [1:0] r);
    case (r)
      RES_14:  return 5'(SHORT_W);
      RES_18:  return 5'(RAW_W);
      default: return 5'(OUT_W);
    endcase
  endfunction
endpackage

// File: rtl/sar_sck_shift.sv
module sar_sck_shift #(
  parameter int unsigned HALF  = 2,
  parameter int unsigned RAW_W = 18,
  parameter int unsigned BC_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BC_W-1:0]  nbits_i,
  input  logic             sdo_i,
  output logic             sck_o,
  output logic             done_o,
  output logic [RAW_W-1:0] raw_o
);
  localparam int unsigned PH_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic             act_q;
  logic [PH_W-1:0]  ph_q;
  logic [BC_W-1:0]  bc_q;
  logic [RAW_W-1:0] sh_q;
  logic             ph_end;

  assign ph_end = (ph_q == PH_W'(HALF - 1));
  assign raw_o  = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      ph_q   <= '0;
      bc_q   <= '0;
      sh_q   <= '0;
      sck_o  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        act_q <= 1'b1;
        ph_q  <= '0;
        bc_q  <= '0;
        sh_q  <= '0;
        sck_o <= 1'b0;
      end else if (act_q) begin
        if (!ph_end) begin
          ph_q <= ph_q + 1'b1;
        end else begin
          ph_q  <= '0;
          sck_o <= ~sck_o;
          if (sck_o) begin
            // sample at end of high phase, bit launched on the rising edge
            sh_q <= {sh_q[RAW_W-2:0], sdo_i};
            bc_q <= bc_q + 1'b1;
            if (bc_q == nbits_i - 1'b1) begin
              act_q  <= 1'b0;
              done_o <= 1'b1;
            end
          end
        end
      end
    end
  end

  p_sck_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q |-> !sck_o);
  p_done_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !sck_o && !act_q);
endmodule

// File: rtl/sar_word_pack.sv
module sar_word_pack import sar_cap_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [RAW_W-1:0] raw_i,
  input  logic [1:0]       res_i,
  input  logic             twos_i,
  output logic [OUT_W-1:0] data_o,
  output logic             drdy_o,
  output logic             busy_o
);
  localparam int unsigned EXT_S = OUT_W - SHORT_W;
  localparam int unsigned EXT_L = OUT_W - (RAW_W - OUT_W);

  logic [1:0]       ph_q;
  logic [OUT_W-1:0] lo_q;
  logic [OUT_W-1:0] first_w;

  always_comb begin
    first_w = raw_i[OUT_W-1:0];
    case (res_i)
      RES_14: first_w = {{EXT_S{twos_i & raw_i[SHORT_W-1]}}, raw_i[SHORT_W-1:0]};
      RES_18: first_w = {{EXT_L{twos_i & raw_i[RAW_W-1]}}, raw_i[RAW_W-1:OUT_W]};
      default: ;
    endcase
  end

  assign busy_o = (ph_q != 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= 2'd0;
      lo_q   <= '0;
      data_o <= '0;
      drdy_o <= 1'b0;
    end else if (load_i) begin
      data_o <= first_w;
      drdy_o <= 1'b1;
      lo_q   <= raw_i[OUT_W-1:0];
      ph_q   <= (res_i == RES_18) ? 2'd1 : 2'd3;
    end else begin
      case (ph_q)
        2'd1: begin drdy_o <= 1'b0; ph_q <= 2'd2; end
        2'd2: begin data_o <= lo_q; drdy_o <= 1'b1; ph_q <= 2'd3; end
        2'd3: begin drdy_o <= 1'b0; ph_q <= 2'd0; end
        default: ;
      endcase
    end
  end

  p_drdy_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drdy_o |=> !drdy_o);
  p_hold_data_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drdy_o |-> $stable(data_o));
endmodule

// File: rtl/sar_capture_ctrl.sv
module sar_capture_ctrl import sar_cap_pkg::*; #(
  parameter int unsigned CNV_W        = 2,
  parameter int unsigned WAIT_NORM    = 12,
  parameter int unsigned WAIT_TURBO   = 6,
  parameter int unsigned PERIOD_NORM  = 140,
  parameter int unsigned PERIOD_TURBO = 110,
  parameter int unsigned SCK_HALF     = 2,
  parameter int unsigned CNT_W        = 8,
  parameter logic        SDI_LEVEL    = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       res_sel_i,
  input  logic             twos_i,
  input  logic             busy_ind_i,
  input  logic             turbo_i,
  input  logic             run_i,
  input  logic             burst_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] burst_cnt_i,
  input  logic             sdo_i,
  output logic             cnv_o,
  output logic             sck_o,
  output logic             sdi_o,
  output logic [15:0]      data_o,
  output logic             drdy_o
);
  localparam int unsigned T_MAX = (PERIOD_NORM > PERIOD_TURBO) ? PERIOD_NORM : PERIOD_TURBO;
  localparam int unsigned T_W   = $clog2(T_MAX + 1);
  localparam int unsigned BC_W  = $clog2(RAW_W + 1);

  ctl_st_e          st_q;
  logic [T_W-1:0]   tmr_q, per_q, wait_len, per_len;
  logic [CNT_W-1:0] rem_q;
  logic             sdo_q, want, per_done, go_cnv, sh_start, sh_done, pk_busy;
  logic [RAW_W-1:0] raw;
  logic [4:0]       nbits5;

  assign wait_len = turbo_i ? T_W'(WAIT_TURBO) : T_W'(WAIT_NORM);
  assign per_len  = turbo_i ? T_W'(PERIOD_TURBO) : T_W'(PERIOD_NORM);
  assign want     = burst_i ? (rem_q != '0) : run_i;
  assign per_done = (per_q >= per_len - 1'b1);
  assign go_cnv   = want && ((st_q == ST_IDLE) || (st_q == ST_GAP && per_done && !pk_busy));
  assign sh_start = (st_q == ST_WAIT) &&
                    (busy_ind_i ? (sdo_q && !sdo_i) : (tmr_q == wait_len - 1'b1));
  assign cnv_o    = (st_q == ST_CNV);
  assign sdi_o    = SDI_LEVEL;
  assign nbits5   = res_bits(res_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
      per_q <= '0;
      rem_q <= '0;
      sdo_q <= 1'b0;
    end else begin
      sdo_q <= sdo_i;
      tmr_q <= tmr_q + 1'b1;
      if (per_q != '1) per_q <= per_q + 1'b1;
      if (st_q == ST_IDLE && burst_i && start_i) rem_q <= burst_cnt_i;
      if (go_cnv) begin
        st_q  <= ST_CNV;
        tmr_q <= '0;
        per_q <= '0;
        if (burst_i) rem_q <= rem_q - 1'b1;
      end else begin
        case (st_q)
          ST_CNV:   if (tmr_q == T_W'(CNV_W - 1)) begin st_q <= ST_WAIT; tmr_q <= '0; end
          ST_WAIT:  if (sh_start) st_q <= ST_SHIFT;
          ST_SHIFT: if (sh_done) st_q <= ST_GAP;
          ST_GAP:   if (per_done && !pk_busy) st_q <= ST_IDLE;
          default:  ;
        endcase
      end
    end
  end

  sar_sck_shift #(.HALF(SCK_HALF), .RAW_W(RAW_W), .BC_W(BC_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sh_start),
    .nbits_i (BC_W'(nbits5)),
    .sdo_i   (sdo_i),
    .sck_o   (sck_o),
    .done_o  (sh_done),
    .raw_o   (raw)
  );

  sar_word_pack u_pack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (sh_done),
    .raw_i   (raw),
    .res_i   (res_sel_i),
    .twos_i  (twos_i),
    .data_o  (data_o),
    .drdy_o  (drdy_o),
    .busy_o  (pk_busy)
  );

  p_cnv_clean_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cnv_o) |-> !sck_o);
  p_no_sck_waiting_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT) |-> !sck_o);
  p_done_in_shift_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_done |-> (st_q == ST_SHIFT));
  p_burst_limit_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cnv_o) && burst_i) |-> ($past(rem_q) != '0));
endmodule

// File: tb/sar_capture_ctrl_tb_top.sv
module sar_capture_ctrl_tb_top;
  localparam int CLK_PERIOD   = 10;
  localparam int CNV_W        = 2;
  localparam int WAIT_NORM    = 12;
  localparam int WAIT_TURBO   = 6;
  localparam int PERIOD_NORM  = 140;
  localparam int PERIOD_TURBO = 110;
  localparam int SCK_HALF     = 2;
  localparam int CONV_FAST    = 5;
  localparam int CONV_BUSY    = 20;
  localparam int WDOG         = 150000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [1:0] res_sel = 2'd1;
  logic twos = 1'b0, busy_ind = 1'b0, turbo = 1'b0, run = 1'b0, burst = 1'b0, start = 1'b0;
  logic [7:0] burst_cnt = 8'd0;
  logic sdo = 1'b0;
  logic cnv, sck, sdi, drdy;
  logic [15:0] data;

  int total = 0, bad = 0, cyc = 0;
  int rises = 0, words = 0;
  bit prev_ok = 1'b0;
  logic [15:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sar_capture_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .res_sel_i(res_sel), .twos_i(twos),
    .busy_ind_i(busy_ind), .turbo_i(turbo), .run_i(run), .burst_i(burst),
    .start_i(start), .burst_cnt_i(burst_cnt), .sdo_i(sdo), .cnv_o(cnv),
    .sck_o(sck), .sdi_o(sdi), .data_o(data), .drdy_o(drdy)
  );

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic int nbits(logic [1:0] r);
    return (r == 2'd0) ? 14 : (r == 2'd2) ? 18 : 16;
  endfunction

  function automatic void push_exp(logic [17:0] s, logic [1:0] r, logic tw);
    if (r == 2'd0) exp_q.push_back({{2{tw & s[13]}}, s[13:0]});
    else if (r == 2'd2) begin
      exp_q.push_back({{14{tw & s[17]}}, s[17:16]});
      exp_q.push_back(s[15:0]);
    end else exp_q.push_back(s[15:0]);
  endfunction

  // converter model and port monitor, all on the falling clock edge
  initial begin
    logic cnv_p = 1'b0, sck_p = 1'b0, drdy_p = 1'b0;
    logic [15:0] data_p = '0;
    logic [17:0] smp = '0;
    int conv_left = 0, bit_idx = 0, sck_cnt = 0, fall_cyc = 0, prev_rise = 0, conv_no = 0, n;
    bit first_sck = 1'b0, early = 1'b0, first_word = 1'b0;
    forever begin
      @(negedge clk);
      if (cyc > WDOG) begin
        chk(1'b0, "watchdog", cyc, WDOG);
        finish_run();
      end
      n = nbits(res_sel);
      if (conv_left > 0) begin
        conv_left--;
        if (conv_left == 0 && busy_ind) sdo = 1'b0;
      end
      if (cnv && !cnv_p) begin
        rises++;
        if (prev_ok)
          chk(cyc - prev_rise == (turbo ? PERIOD_TURBO : PERIOD_NORM), "R10 cnv spacing",
              cyc - prev_rise, turbo ? PERIOD_TURBO : PERIOD_NORM);
        prev_rise = cyc;
        prev_ok = 1'b1;
        chk(!sck, "R2 sck low at cnv rise", sck, 0);
        case (conv_no % 4)
          0: smp = 18'((1 << n) - 1);
          1: smp = 18'(1 << (n - 1));
          2: smp = '0;
          default: smp = 18'($urandom & ((1 << n) - 1));
        endcase
        conv_no++;
        push_exp(smp, res_sel, twos);
        conv_left = busy_ind ? CONV_BUSY : CONV_FAST;
        sdo = busy_ind;
        bit_idx = n; sck_cnt = 0; first_sck = 1'b1; early = 1'b0; first_word = 1'b1;
      end
      if (!cnv && cnv_p) begin
        fall_cyc = cyc;
        chk(cyc - prev_rise == CNV_W, "R2 cnv width", cyc - prev_rise, CNV_W);
      end
      if (sck && !sck_p) begin
        if (conv_left != 0) early = 1'b1;
        sck_cnt++;
        if (first_sck && !busy_ind)
          chk(cyc - fall_cyc == (turbo ? WAIT_TURBO : WAIT_NORM) + SCK_HALF, "R3 wait",
              cyc - fall_cyc, (turbo ? WAIT_TURBO : WAIT_NORM) + SCK_HALF);
        first_sck = 1'b0;
        if (bit_idx > 0) begin
          sdo = smp[bit_idx-1];
          bit_idx--;
        end
      end
      if (!drdy && data != data_p) chk(1'b0, "R9 data moved without drdy", data, data_p);
      if (drdy) begin
        chk(!drdy_p, "R9 single-cycle drdy", drdy_p, 0);
        if (first_word) begin
          chk(sck_cnt == n, "R5 sck edge count", sck_cnt, n);
          chk(!early, "R4 sck before sdo fall", early, 0);
          first_word = 1'b0;
        end
        if (exp_q.size() == 0) chk(1'b0, "R6/R7/R8 unexpected word", data, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(data == e, res_sel == 2'd0 ? "R6 word" : res_sel == 2'd2 ? "R8 word" : "R7 word",
              data, e);
        end
        words++;
      end
      cnv_p = cnv; sck_p = sck; drdy_p = drdy; data_p = data;
    end
  end

  task automatic run_cont(logic [1:0] r, logic tw, logic tb, logic bi);
    int target, m;
    @(negedge clk);
    res_sel = r; twos = tw; turbo = tb; busy_ind = bi; burst = 1'b0;
    prev_ok = 1'b0;
    target = words + 4 * ((r == 2'd2) ? 2 : 1);
    run = 1'b1;
    while (words < target) @(negedge clk);
    run = 1'b0;
    repeat (300) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all results delivered", exp_q.size(), 0);
    m = rises;
    repeat (150) @(negedge clk);
    chk(rises == m, "R10 stop after run drops", rises - m, 0);
  endtask

  task automatic run_burst(int cnt, logic tb);
    int m;
    @(negedge clk);
    burst = 1'b1; turbo = tb; prev_ok = 1'b0; burst_cnt = 8'(cnt);
    m = rises;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (cnt * PERIOD_NORM + 300) @(negedge clk);
    chk(rises - m == cnt, "R11 burst count", rises - m, cnt);
    chk(exp_q.size() == 0, "R11 burst results delivered", exp_q.size(), 0);
    burst = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0011));
    repeat (3) @(negedge clk);
    chk(!cnv && !sck && !drdy, "R1 reset outputs", {cnv, sck, drdy}, 0);
    chk(data == 16'h0, "R1 reset data", data, 0);
    chk(sdi == 1'b1, "R12 sdi level", sdi, 1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!cnv && !sck && !drdy && data == 0, "R1 after release", {cnv, sck, drdy}, 0);
    run_cont(2'd1, 1'b0, 1'b0, 1'b0);
    run_cont(2'd0, 1'b1, 1'b1, 1'b0);
    run_cont(2'd0, 1'b0, 1'b0, 1'b1);
    run_cont(2'd2, 1'b1, 1'b0, 1'b1);
    run_cont(2'd2, 1'b0, 1'b1, 1'b0);
    run_cont(2'd3, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 6; i++)
      run_cont(2'($urandom % 3), 1'($urandom), 1'($urandom), 1'($urandom));
    run_burst(3, 1'b0);
    run_burst(2, 1'b1);
    run_burst(0, 1'b0);
    chk(sdi == 1'b1, "R12 sdi level at end", sdi, 1);
    finish_run();
  end
endmodule